// File: doc/BRIEF.md
# GPIO Pin Event Generator

This block watches a 32-pin input port and turns selected pin transitions into single-cycle pulses for a peripheral event system. Each pin has its own trigger mode: any level change, a rising edge, or a falling edge. Each pin also has an event enable bit and an optional glitch filter. Pins are synchronised with two flops before any edge is detected. When a pin's filter is on, a new level must hold for two synchronised samples before it is accepted.

The per-pin results are ORed in groups of eight consecutive pins, which gives four event lines. Line 0 covers pins 0 to 7, line 1 covers pins 8 to 15, line 2 covers pins 16 to 23 and line 3 covers pins 24 to 31. A small write-only register port loads the enable, mode and filter words.

Event generation depends only on the enable and mode bits. Interrupt enabling lives elsewhere and has no effect on this block. Each pin's previous accepted level is held in a register. Because of this, changing the configuration never creates an event while the pin is steady.

Top module: `gpev_top`

## Requirements
- R1: During reset and on the first edge after it is released, every event line is 0 and the enable and filter words are cleared. A pin toggled after reset, with no configuration written, produces no event.
- R2: With mode 00 (any change), both a rising and a falling pin change give an event. A pin change set up before clock edge 1 gives a pulse in the cycle that follows edge 3, when the filter is off.
- R3: With mode 01 (rising), a 0-to-1 change gives an event and a 1-to-0 change gives none.
- R4: With mode 10 (falling), a 1-to-0 change gives an event and a 0-to-1 change gives none.
- R5: Mode 11 is reserved and never gives an event.
- R6: A pin whose event enable bit is 0 gives no event in any mode.
- R7: Line g is the OR of the events of pins 8g to 8g+7. Changes on several pins of one group in the same cycle give one single-cycle pulse. Other lines stay at 0.
- R8: With the filter on, a synchronised level that lasts only one cycle is rejected. An accepted change arrives two cycles later than without the filter, which puts the pulse after edge 5.
- R9: Writing the enable, mode or filter registers while a pin is steady produces no event.
- R10: A write is made when cfg_we_i is 1 and takes effect from the next cycle. The address selects the word written: 0 is the event enable word, 1 is the mode low bit of every pin, 2 is the mode high bit of every pin, and 3 is the filter enable word. Bit i of each word belongs to pin i, and a pin's mode is {high bit, low bit}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Asynchronous pin levels |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration word select |
| cfg_wdata_i | input | 32 | Configuration write data, one bit per pin |
| evt_line_o | output | 4 | Event pulse, one line per group of eight pins |

## Verification
Some properties are checked on every cycle. A group with no enabled pin never pulses, and neither does a group whose enabled pins are all in the reserved mode. A group whose accepted levels did not move stays quiet on the next cycle. A filtered pin changes its accepted level only after two equal synchronised samples. The bench scenarios are needed for the rest: the exact pulse cycle with and without the filter, the direction selectivity of each mode, glitch rejection, the grouping onto lines, and the absence of events while the configuration is rewritten with the pins held steady.

// File: rtl/gpev_pkg.sv
package gpev_pkg;
    localparam int CFG_AW = 2;

    localparam logic [CFG_AW-1:0] ADDR_ENABLE  = 2'd0;
    localparam logic [CFG_AW-1:0] ADDR_MODE_LO = 2'd1;
    localparam logic [CFG_AW-1:0] ADDR_MODE_HI = 2'd2;
    localparam logic [CFG_AW-1:0] ADDR_FILTER  = 2'd3;

    typedef enum logic [1:0] {
        TRIG_ANY  = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_NONE = 2'b11
    } trig_e;

    function automatic logic pin_hit(input trig_e mode, input logic cur, input logic old);
        case (mode)
            TRIG_ANY:  return cur ^ old;
            TRIG_RISE: return cur & ~old;
            TRIG_FALL: return ~cur & old;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/gpev_cfg.sv
module gpev_cfg
    import gpev_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [CFG_AW-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    output logic [N-1:0]      en_o,
    output logic [N-1:0]      mode_lo_o,
    output logic [N-1:0]      mode_hi_o,
    output logic [N-1:0]      filt_o
);
    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] mlo;
        logic [N-1:0] mhi;
        logic [N-1:0] flt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (addr_i)
                ADDR_ENABLE:  cfg_d.en  = wdata_i;
                ADDR_MODE_LO: cfg_d.mlo = wdata_i;
                ADDR_MODE_HI: cfg_d.mhi = wdata_i;
                default:      cfg_d.flt = wdata_i;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign en_o      = cfg_q.en;
    assign mode_lo_o = cfg_q.mlo;
    assign mode_hi_o = cfg_q.mhi;
    assign filt_o    = cfg_q.flt;
endmodule

// File: rtl/gpev_front.sv
module gpev_front #(
    parameter int N = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] filt_en_i,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] filt_o,
    output logic [N-1:0] lvl_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s_prev;
        logic [N-1:0] filt;
    } front_t;

    front_t fr_d, fr_q;
    logic [N-1:0] hold;

    always_comb begin
        fr_d        = fr_q;
        fr_d.s1     = pin_i;
        fr_d.s2     = fr_q.s1;
        fr_d.s_prev = fr_q.s2;
        // a filtered pin keeps its old level until two samples agree
        hold        = filt_en_i & (fr_q.s2 ^ fr_q.s_prev);
        fr_d.filt   = (fr_q.s2 & ~hold) | (fr_q.filt & hold);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fr_q <= '0;
        else         fr_q <= fr_d;
    end

    assign sync_o = fr_q.s2;
    assign filt_o = fr_q.filt;
    assign lvl_o  = (filt_en_i & fr_q.filt) | (~filt_en_i & fr_q.s2);
endmodule

// File: rtl/gpev_detect.sv
module gpev_detect
    import gpev_pkg::*;
#(
    parameter int N = 32,
    parameter int G = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N-1:0]     lvl_i,
    input  logic [N-1:0]     en_i,
    input  logic [N-1:0]     mode_lo_i,
    input  logic [N-1:0]     mode_hi_i,
    output logic [N/G-1:0]   line_o
);
    localparam int L = N / G;

    typedef struct packed {
        logic [N-1:0] prev;
        logic [L-1:0] line;
    } det_t;

    det_t dt_d, dt_q;
    logic [N-1:0] hit;

    for (genvar p = 0; p < N; p++) begin : g_pin
        assign hit[p] = en_i[p] &
                        pin_hit(trig_e'({mode_hi_i[p], mode_lo_i[p]}), lvl_i[p], dt_q.prev[p]);
    end

    logic [L-1:0] grp_hit;
    for (genvar g = 0; g < L; g++) begin : g_grp
        assign grp_hit[g] = |hit[g*G +: G];
    end

    always_comb begin
        dt_d      = dt_q;
        dt_d.prev = lvl_i;
        dt_d.line = grp_hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dt_q <= '0;
        else         dt_q <= dt_d;
    end

    assign line_o = dt_q.line;
endmodule

// File: rtl/gpev_top.sv
module gpev_top
    import gpev_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int GROUP_SIZE = 8,
    localparam int NUM_LINES = NUM_PINS / GROUP_SIZE
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_PINS-1:0]  pin_i,
    input  logic                 cfg_we_i,
    input  logic [CFG_AW-1:0]    cfg_addr_i,
    input  logic [NUM_PINS-1:0]  cfg_wdata_i,
    output logic [NUM_LINES-1:0] evt_line_o
);
    logic [NUM_PINS-1:0] en_w, mlo_w, mhi_w, flt_w;
    logic [NUM_PINS-1:0] sync_w, filt_w, lvl_w;

    gpev_cfg #(.N(NUM_PINS)) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (cfg_we_i),
        .addr_i    (cfg_addr_i),
        .wdata_i   (cfg_wdata_i),
        .en_o      (en_w),
        .mode_lo_o (mlo_w),
        .mode_hi_o (mhi_w),
        .filt_o    (flt_w)
    );

    gpev_front #(.N(NUM_PINS)) u_front (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pin_i     (pin_i),
        .filt_en_i (flt_w),
        .sync_o    (sync_w),
        .filt_o    (filt_w),
        .lvl_o     (lvl_w)
    );

    gpev_detect #(.N(NUM_PINS), .G(GROUP_SIZE)) u_detect (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lvl_i     (lvl_w),
        .en_i      (en_w),
        .mode_lo_i (mlo_w),
        .mode_hi_i (mhi_w),
        .line_o    (evt_line_o)
    );
endmodule

// File: rtl/gpev_chk.sv
module gpev_chk #(
    parameter int N = 32,
    parameter int G = 8
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic [N-1:0]   en,
    input logic [N-1:0]   mlo,
    input logic [N-1:0]   mhi,
    input logic [N-1:0]   flt,
    input logic [N-1:0]   sync,
    input logic [N-1:0]   filt,
    input logic [N-1:0]   lvl,
    input logic [N/G-1:0] line
);
    localparam int L = N / G;

    AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (line == '0 && en == '0 && flt == '0)); // R1

    AST_FILTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(flt) & (filt ^ $past(filt)) & ($past(sync) ^ $past(sync, 2))) == '0); // R8

    for (genvar g = 0; g < L; g++) begin : g_line
        AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en[g*G +: G] == '0) |=> !line[g]); // R6

        AST_RESERVED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((en[g*G +: G] & ~(mlo[g*G +: G] & mhi[g*G +: G])) == '0) |=> !line[g]); // R5

        AST_STEADY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $stable(lvl[g*G +: G]) |=> !line[g]); // R9
    end
endmodule

bind gpev_top gpev_chk #(.N(NUM_PINS), .G(GROUP_SIZE)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en     (en_w),
    .mlo    (mlo_w),
    .mhi    (mhi_w),
    .flt    (flt_w),
    .sync   (sync_w),
    .filt   (filt_w),
    .lvl    (lvl_w),
    .line   (evt_line_o)
);

// File: tb/tb_gpev_top.sv
module tb_gpev_top;
    localparam int NP = 32;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          we = 1'b0;
    logic [1:0]    addr = '0;
    logic [NP-1:0] wdata = '0;
    logic [NL-1:0] evt;

    logic [NP-1:0] sh_en = '0, sh_lo = '0, sh_hi = '0, sh_flt = '0;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpev_top dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pins),
        .cfg_we_i    (we),
        .cfg_addr_i  (addr),
        .cfg_wdata_i (wdata),
        .evt_line_o  (evt)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [NP-1:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_mode(input int p, input logic [1:0] m);
        sh_lo[p] = m[0]; sh_hi[p] = m[1];
        wr(2'd1, sh_lo);
        wr(2'd2, sh_hi);
    endtask

    // Watch 8 negedges after a stimulus applied at a negedge.
    // exp_cycle 0 means no pulse expected on the line.
    task automatic watch(input int ln, input int exp_cycle, input string tag);
        int first = 0;
        int cnt = 0;
        int other = 0;
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (evt[ln]) begin
                cnt++;
                if (first == 0) first = c;
            end
            for (int j = 0; j < NL; j++)
                if (j != ln && evt[j]) other++;
        end
        if (exp_cycle == 0)
            check(cnt == 0, tag, cnt, 0);
        else begin
            check(cnt == 1, {tag, " pulse count"}, cnt, 1);
            check(first == exp_cycle, {tag, " pulse cycle"}, first, exp_cycle);
        end
        check(other == 0, {tag, " other lines"}, other, 0);
    endtask

    task automatic t_reset;
        check(evt == '0, "R1 lines in reset", int'(evt), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(evt == '0, "R1 lines after reset", int'(evt), 0);
        pins[2] = 1'b1;
        watch(0, 0, "R1 unconfigured pin");
    endtask

    task automatic t_any;
        sh_en[3] = 1'b1; wr(2'd0, sh_en);
        set_mode(3, 2'b00);
        pins[3] = 1'b1; watch(0, 3, "R2 any rise");
        pins[3] = 1'b0; watch(0, 3, "R2 any fall");
    endtask

    task automatic t_rise;
        sh_en[10] = 1'b1; wr(2'd0, sh_en);
        set_mode(10, 2'b01);
        pins[10] = 1'b1; watch(1, 3, "R3 R10 rise mode rise");
        pins[10] = 1'b0; watch(1, 0, "R3 rise mode fall");
    endtask

    task automatic t_fall;
        sh_en[20] = 1'b1; wr(2'd0, sh_en);
        set_mode(20, 2'b10);
        pins[20] = 1'b1; watch(2, 0, "R4 fall mode rise");
        pins[20] = 1'b0; watch(2, 3, "R4 fall mode fall");
    endtask

    task automatic t_reserved;
        sh_en[28] = 1'b1; wr(2'd0, sh_en);
        set_mode(28, 2'b11);
        pins[28] = 1'b1; watch(3, 0, "R5 reserved rise");
        pins[28] = 1'b0; watch(3, 0, "R5 reserved fall");
    endtask

    task automatic t_enable;
        set_mode(5, 2'b00);
        pins[5] = 1'b1; watch(0, 0, "R6 disabled rise");
        pins[5] = 1'b0; watch(0, 0, "R6 disabled fall");
    endtask

    task automatic t_group;
        sh_en[24] = 1'b1; sh_en[31] = 1'b1; wr(2'd0, sh_en);
        set_mode(24, 2'b00); set_mode(31, 2'b00);
        pins[24] = 1'b1; pins[31] = 1'b1; watch(3, 3, "R7 two pins one pulse");
        pins[31] = 1'b0; watch(3, 3, "R7 top pin of group");
        pins[26] = 1'b1; watch(3, 0, "R7 disabled member");
    endtask

    task automatic t_filter;
        sh_en[12] = 1'b1; wr(2'd0, sh_en);
        set_mode(12, 2'b00);
        sh_flt[12] = 1'b1; wr(2'd3, sh_flt);
        pins[12] = 1'b1;
        @(negedge clk);
        pins[12] = 1'b0;
        watch(1, 0, "R8 glitch rejected");
        pins[12] = 1'b1; watch(1, 5, "R8 filtered rise");
        pins[12] = 1'b0; watch(1, 5, "R8 filtered fall");
    endtask

    task automatic t_cfgchg;
        pins[15] = 1'b1; watch(1, 0, "R9 pin set while disabled");
        sh_en[15] = 1'b1;
        we = 1'b1; addr = 2'd0; wdata = sh_en;
        @(negedge clk); we = 1'b0;
        watch(1, 0, "R9 enable write");
        set_mode(15, 2'b01); watch(1, 0, "R9 mode to rise");
        set_mode(15, 2'b10); watch(1, 0, "R9 mode to fall");
        sh_flt[15] = 1'b1; wr(2'd3, sh_flt); watch(1, 0, "R9 filter on");
        sh_flt[15] = 1'b0; wr(2'd3, sh_flt); watch(1, 0, "R9 filter off");
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_any;
        t_rise;
        t_fall;
        t_reserved;
        t_enable;
        t_group;
        t_filter;
        t_cfgchg;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule